// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Up-Counter

This block is a binary up-counter built from identical 4-bit slices. The slices are chained into one wide counter without any extra gating. Each slice has two count enables:

- The "parallel" enable is shared by every slice and only gates counting.
- The "trickle" enable gates counting and also qualifies that slice's carry.

A slice's carry is high only when its trickle enable is high and its nibble is all ones. That carry becomes the trickle enable of the next slice up, so a higher nibble advances only when every nibble below it is at its maximum.

The counter has no asynchronous clear in its function. Clear, parallel load and counting all act at the rising clock edge, with a fixed priority:

1. Clear is highest.
2. Load is next.
3. Counting is last.

Level changes on the controls between edges leave the stored value alone. A shorter count cycle is made outside the block. Decode the chosen terminal value into a low level on the clear input, and the counter returns to zero on the next edge. The only asynchronous input is a chip-level reset, whose release is synchronised inside the block.

Top module: `ctr_chain`

## Requirements
- R1: While `rst_n` is low, `count` is zero, independent of the clock. After `rst_n` rises, the state is held at zero until the internal reset release has passed two rising edges.
- R2: A low `clr_n` at a rising edge makes `count` zero, whatever `load_n`, `en_par`, `en_trk` and `load_val` are.
- R3: With `clr_n` high and `load_n` low at a rising edge, `count` takes `load_val`, whatever the enables are. Bits [3:0] of `load_val` go to the least-significant slice.
- R4: With `clr_n` and `load_n` high and both enables high, `count` increases by one at each rising edge.
- R5: With `clr_n` and `load_n` high and either enable low, `count` holds its value.
- R6: `carry_out` is high exactly when `en_trk` is high and every bit of `count` is 1. It follows `en_trk` combinationally, without waiting for an edge.
- R7: Slices cascade through their carries, so the whole counter steps as one binary number of width 4×STAGES. It wraps from all ones to zero.
- R8: Feeding back a decode of value 9 as a low level on `clr_n`, with both enables high, makes `count` run through 0 to 9 repeatedly.
- R9: Level changes on `load_n`, `en_par`, `en_trk` or `load_val` between two rising edges have no effect on `count`. Only the levels present at the edge matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_par | input | 1 | Count enable shared by all slices |
| en_trk | input | 1 | Count enable of the lowest slice; also qualifies the carry |
| load_val | input | 4×STAGES | Parallel load value, bits [3:0] to the lowest slice |
| count | output | 4×STAGES | Current counter value |
| carry_out | output | 1 | High when `en_trk` is high and the count is all ones |

## Verification
The clocked properties assume the controls and the load value are stable across each rising edge. They also assume the reset has been released for long enough that the synchronised release has taken effect. The bench meets both assumptions by changing every input a quarter period after a rising edge. It toggles controls in mid-cycle only in the test that checks those changes are ignored, and it restores them before the next edge. For the truncated-modulus test, the clear is decoded from `count` as sampled by the bench, then applied before the following edge. This mirrors an external decode gate without creating a combinational loop inside the block.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;

  // Fixed priority: clear, then load, then count.
  function automatic ctr_op_e pick_op(input logic clr_n, input logic load_n,
                                      input logic en_p, input logic en_t);
    if (!clr_n)            return OP_CLEAR;
    else if (!load_n)      return OP_LOAD;
    else if (en_p && en_t) return OP_COUNT;
    else                   return OP_HOLD;
  endfunction

endpackage

// File: rtl/ctr_rst_sync.sv
module ctr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_r <= '0;
    else        pipe_r <= {pipe_r[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_r[STAGES-1];
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice
  import ctr_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         rco
);
  ctr_op_e      op;
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;
  logic         upd;

  // next-state
  always_comb begin
    op    = pick_op(clr_n, load_n, en_p, en_t);
    q_nxt = q_r;
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = d;
      OP_COUNT: q_nxt = q_r + W'(1);
      default:  q_nxt = q_r;
    endcase
    upd = (op != OP_HOLD);
  end

  // register with explicit clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_r <= '0;
    else if (upd) q_r <= q_nxt;
  end

  assign q   = q_r;
  assign rco = en_t & (&q_r);

  // R2
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |=> (q == '0));

  // R3
  load_takes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && !load_n) |=> (q == $past(d)));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && en_p && en_t) |=> (q == W'($past(q) + 1'b1)));

  // R5
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_n && load_n && !(en_p && en_t)) |=> $stable(q));
endmodule

// File: rtl/ctr_chain.sv
module ctr_chain #(
  parameter int STAGES  = 2,
  parameter int SLICE_W = 4,
  parameter int SYNC_FF = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_n,
  input  logic                        load_n,
  input  logic                        en_par,
  input  logic                        en_trk,
  input  logic [STAGES*SLICE_W-1:0]   load_val,
  output logic [STAGES*SLICE_W-1:0]   count,
  output logic                        carry_out
);
  localparam int TOTAL_W = STAGES * SLICE_W;

  logic            rst_n_int;
  logic [STAGES:0] trk_chain;

  ctr_rst_sync #(.STAGES(SYNC_FF)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign trk_chain[0] = en_trk;

  for (genvar k = 0; k < STAGES; k++) begin : g_slice
    ctr_slice #(.W(SLICE_W)) slice_i (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .clr_n  (clr_n),
      .load_n (load_n),
      .en_p   (en_par),
      .en_t   (trk_chain[k]),
      .d      (load_val[k*SLICE_W +: SLICE_W]),
      .q      (count[k*SLICE_W +: SLICE_W]),
      .rco    (trk_chain[k+1])
    );
  end

  assign carry_out = trk_chain[STAGES];

  // R6
  carry_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    carry_out |-> (en_trk && (&count)));

  // R6
  carry_complete_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (en_trk && (&count)) |-> carry_out);

  // R7
  full_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (clr_n && load_n && en_par && en_trk && (&count)) |=> (count == '0));

  // R7
  whole_step_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (clr_n && load_n && en_par && en_trk) |=> (count == TOTAL_W'($past(count) + 1'b1)));
endmodule

// File: tb/ctr_chain_tb.sv
module ctr_chain_tb_top;
  localparam int CLK_P  = 10;
  localparam int N_STG  = 2;
  localparam int TOTAL  = N_STG * 4;
  localparam int N_VEC  = 14;
  localparam int VEC_W  = 4 + 2*TOTAL + 1;

  logic             clk;
  logic             rst_n;
  logic             clr_n;
  logic             load_n;
  logic             en_par;
  logic             en_trk;
  logic [TOTAL-1:0] load_val;
  logic [TOTAL-1:0] count;
  logic             carry_out;

  int n_chk  = 0;
  int n_fail = 0;

  // {clr_n, load_n, en_par, en_trk, load_val, expected count, expected carry}
  localparam logic [VEC_W-1:0] VECS [N_VEC] = '{
    {4'b0111, 8'h00, 8'h00, 1'b0},  // clear
    {4'b1011, 8'hFC, 8'hFC, 1'b0},  // load 252
    {4'b1111, 8'h00, 8'hFD, 1'b0},
    {4'b1111, 8'h00, 8'hFE, 1'b0},
    {4'b1111, 8'h00, 8'hFF, 1'b1},  // maximum, carry up
    {4'b1111, 8'h00, 8'h00, 1'b0},  // wrap
    {4'b1111, 8'h00, 8'h01, 1'b0},
    {4'b1111, 8'h00, 8'h02, 1'b0},
    {4'b1101, 8'h00, 8'h02, 1'b0},  // en_par low: hold
    {4'b1110, 8'h00, 8'h02, 1'b0},  // en_trk low: hold
    {4'b1010, 8'hFF, 8'hFF, 1'b0},  // load max, carry gated off
    {4'b1101, 8'h00, 8'hFF, 1'b1},  // en_trk high: carry
    {4'b0011, 8'h55, 8'h00, 1'b0},  // clear beats load
    {4'b1000, 8'h3A, 8'h3A, 1'b0}   // load with enables low
  };

  ctr_chain #(.STAGES(N_STG), .SLICE_W(4), .SYNC_FF(2)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .en_par    (en_par),
    .en_trk    (en_trk),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [TOTAL-1:0] act,
                     input logic [TOTAL-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p,
                       input logic t, input logic [TOTAL-1:0] v);
    clr_n = c; load_n = l; en_par = p; en_trk = t; load_val = v;
  endtask

  task automatic tick;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [TOTAL-1:0] model;
    logic [TOTAL-1:0] v;
    logic c, l, p, t;

    // R1: reset state, carry low even with en_trk high
    rst_n = 1'b0;
    drive(1'b1, 1'b1, 1'b0, 1'b1, '0);
    repeat (3) tick();
    chk("R1 count in reset", count, '0);
    chk("R1 carry in reset", {7'b0, carry_out}, '0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk("R1 count after release", count, '0);

    // R2-R7: stimulus table
    for (int i = 0; i < N_VEC; i++) begin
      logic [VEC_W-1:0] e;
      e = VECS[i];
      drive(e[VEC_W-1], e[VEC_W-2], e[VEC_W-3], e[VEC_W-4],
            e[2*TOTAL:TOTAL+1]);
      tick();
      chk($sformatf("R2/R3/R4/R5 table step %0d count", i), count, e[TOTAL:1]);
      chk($sformatf("R6 table step %0d carry", i), {7'b0, carry_out}, {7'b0, e[0]});
    end

    // R1: asynchronous assertion in mid-cycle
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h5F);
    tick();
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset clears", count, '0);
    #(CLK_P);
    rst_n = 1'b1;
    repeat (4) tick();

    // R6: carry follows en_trk without an edge
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'hFF);
    tick();
    drive(1'b1, 1'b1, 1'b0, 1'b0, '0);
    #1;
    chk("R6 carry low with en_trk low", {7'b0, carry_out}, '0);
    en_trk = 1'b1;
    #1;
    chk("R6 carry follows en_trk", {7'b0, carry_out}, 8'h01);
    en_trk = 1'b0;
    #1;
    chk("R6 carry drops with en_trk", {7'b0, carry_out}, '0);

    // R9: mid-cycle changes undone before the edge
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h10);
    tick();
    drive(1'b1, 1'b0, 1'b1, 1'b1, 8'hAA);
    #(CLK_P/4);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 8'h00);
    tick();
    chk("R9 glitch ignored", count, 8'h10);

    // R7: carry across nibble boundary
    drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h0F);
    tick();
    drive(1'b1, 1'b1, 1'b1, 1'b1, '0);
    tick();
    chk("R7 nibble carry", count, 8'h10);

    // R8: divide-by-10 via decoded clear
    drive(1'b0, 1'b1, 1'b1, 1'b1, '0);
    tick();
    model = '0;
    for (int i = 0; i < 25; i++) begin
      logic [TOTAL-1:0] nx;
      nx = (model == 8'd9) ? 8'd0 : model + 8'd1;
      drive(count != 8'd9, 1'b1, 1'b1, 1'b1, '0);
      tick();
      chk($sformatf("R8 mod10 step %0d", i), count, nx);
      model = nx;
    end

    // R2-R7: randomised against a reference model
    drive(1'b0, 1'b1, 1'b0, 1'b0, '0);
    tick();
    model = '0;
    for (int i = 0; i < 600; i++) begin
      c = ($urandom_range(15) != 0);
      l = ($urandom_range(7) != 0);
      p = ($urandom_range(3) != 0);
      t = ($urandom_range(3) != 0);
      v = ($urandom_range(3) == 0) ? 8'hFF - 8'($urandom_range(3))
                                   : 8'($urandom);
      drive(c, l, p, t, v);
      tick();
      if (!c)          model = '0;
      else if (!l)     model = v;
      else if (p && t) model = model + 8'd1;
      chk($sformatf("R4/R5/R7 random %0d count", i), count, model);
      chk($sformatf("R6 random %0d carry", i), {7'b0, carry_out},
          {7'b0, (t && model == 8'hFF)});
    end

    summary();
  end
endmodule